// File: doc/BRIEF.md
# Carrier-Gap Downlink Bit Decoder

This block sits in a passive tag and turns carrier interruptions sent by the reader into data bits. A strobe arrives once per carrier period, and a gap-detect level goes high while the carrier is absent. The block counts carrier periods into 32-period bit slots. In the first half of every slot it enables the tag's load modulator. A carrier gap that starts in that first half marks a logic zero. A slot with an unbroken carrier is a logic one.

The block starts in standby. The tag's sequencer raises `liw_mod` during the modulated phase of each listen window. A gap that starts while `liw_mod` is high stops the listen window at once, and the block raises a one-cycle stop pulse. Receive mode is confirmed only when a second zero arrives in the next slot. If that slot carries no gap, the block pulses a failure flag and returns to standby. In receive mode the block emits one valid strobe per slot together with the decoded bit. It stays in receive mode until the sequencer pulses the release input.

The extracted clock can slip by one carrier period per bit. The slot counter therefore reloads to a fixed count whenever a qualifying gap ends, so each zero re-aligns the bit timing.

Top module: `gap_bit_decoder`

## Requirements
- R1: After reset, every output is low and the slot counter is at count 0.
- R2: The slot counter advances on each carrier strobe from 0 to 31 and wraps. A slot ends on the strobe taken at count 31, so a carrier-only slot needs exactly 32 strobes.
- R3: Carrier strobes that arrive while the gap level is high do not move the counter.
- R4: When a qualifying gap ends, the counter reloads to 16. The following 16 strobes end the slot, so a zero whose gap starts after 1 to 6 strobes still decodes and keeps the following bits aligned.
- R5: `mod_en` is high at counts 0 to 15 whenever the block is not in standby. It is low at counts 16 to 31, and it is always low in standby.
- R6: In receive mode, each slot produces exactly one single-cycle `bit_valid` pulse. `bit_value` is 0 if a gap started at a count below 16, and 1 otherwise.
- R7: A gap that starts at count 16 or later in receive mode is ignored. The slot decodes as 1, and the counter is not reloaded.
- R8: In standby, a gap that starts while `liw_mod` is high raises a one-cycle `liw_stop` pulse and begins entry. A gap that starts while `liw_mod` is low has no effect.
- R9: A zero in the slot after the first zero raises `rm_entered`. Neither entry slot produces a `bit_valid` pulse.
- R10: If the slot after the first zero has no gap, the block raises a one-cycle `entry_fail` pulse and returns to standby, with `rm_entered` and `mod_en` low.
- R11: A `rx_release` pulse returns the block to standby. After that, slots produce no `bit_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the carrier |
| rst_n | input | 1 | Active-low asynchronous reset |
| car_tick | input | 1 | One-cycle strobe per extracted carrier period |
| gap_det | input | 1 | High while the carrier is missing (asynchronous level) |
| liw_mod | input | 1 | High during the modulated phase of a listen window |
| rx_release | input | 1 | Pulse that returns the block to standby |
| mod_en | output | 1 | Load-modulator enable for the first half of each slot |
| liw_stop | output | 1 | Pulse: listen window must stop, entry has started |
| rm_entered | output | 1 | High while receive mode is confirmed |
| entry_fail | output | 1 | Pulse: second entry zero was missing |
| bit_valid | output | 1 | Pulse: one decoded bit is ready |
| bit_value | output | 1 | Decoded bit, valid with `bit_valid` |

## Verification
The assertions assume that `car_tick` never stays high for two adjacent clock cycles. They also assume that no strobe arrives in the few cycles after the gap level changes, while the synchroniser and the counter reload settle. The bench spaces strobes four clocks apart. It changes `gap_det` only on the clock after a strobe, and it waits four clocks after a gap ends before the next strobe. That way every gap edge reaches the counter logic before the next carrier period. Strobes sent on purpose during a gap are placed after the synchronised level has already risen.

// File: rtl/gbd_pkg.sv
package gbd_pkg;
   typedef enum logic [1:0] {
      ST_STANDBY = 2'd0,
      ST_FIRST   = 2'd1,
      ST_SECOND  = 2'd2,
      ST_RECEIVE = 2'd3
   } rx_state_t;
endpackage

// File: rtl/gbd_gap_sync.sv
module gbd_gap_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gap_raw,
   output logic gap_lvl,
   output logic gap_rise,
   output logic gap_fall
);
   logic gap_prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign gap_lvl = gap_raw;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-1:0], gap_raw} >> 0;
         end
         assign gap_lvl = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gap_prev <= 1'b0;
      else        gap_prev <= gap_lvl;
   end

   assign gap_rise = gap_lvl & ~gap_prev;
   assign gap_fall = ~gap_lvl & gap_prev;
endmodule

// File: rtl/gbd_bit_timer.sv
module gbd_bit_timer #(
   parameter int BIT_LEN    = 32,
   parameter int RESYNC_CNT = 16,
   localparam int CW        = $clog2(BIT_LEN),
   localparam int HALF      = BIT_LEN / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          hold,
   input  logic          resync,
   output logic [CW-1:0] cnt,
   output logic          first_half,
   output logic          bit_end
);
   localparam logic [CW-1:0] LAST   = CW'(BIT_LEN - 1);
   localparam logic [CW-1:0] RELOAD = CW'(RESYNC_CNT);
   localparam logic [CW-1:0] MID    = CW'(HALF);
   localparam logic [CW-1:0] STEP   = CW'(1);

   logic advance;

   assign advance    = tick & ~hold;
   assign bit_end    = advance & (cnt == LAST);
   assign first_half = (cnt < MID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (resync) begin
         cnt <= RELOAD;
      end else if (advance) begin
         if (cnt == LAST) cnt <= '0;
         else             cnt <= cnt + STEP;
      end
   end
endmodule

// File: rtl/gbd_entry_fsm.sv
module gbd_entry_fsm
   import gbd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      gap_rise,
   input  logic      gap_fall,
   input  logic      liw_mod,
   input  logic      first_half,
   input  logic      bit_end,
   input  logic      release_req,
   output rx_state_t state,
   output logic      resync,
   output logic      liw_stop,
   output logic      entry_fail,
   output logic      bit_valid,
   output logic      bit_value
);
   logic      qual_rise;
   logic      gap_open;
   logic      zero_seen;
   logic      listening;
   rx_state_t state_nx;

   assign listening = (state == ST_SECOND) || (state == ST_RECEIVE);
   assign qual_rise = gap_rise &
                      (((state == ST_STANDBY) & liw_mod) | (listening & first_half));
   assign resync    = gap_fall & gap_open;

   always_comb begin
      state_nx = state;
      if (release_req) begin
         state_nx = ST_STANDBY;
      end else begin
         unique case (state)
            ST_STANDBY: if (qual_rise) state_nx = ST_FIRST;
            ST_FIRST:   if (bit_end)   state_nx = ST_SECOND;
            ST_SECOND:  if (bit_end)   state_nx = zero_seen ? ST_RECEIVE : ST_STANDBY;
            ST_RECEIVE: state_nx = ST_RECEIVE;
            default:    state_nx = ST_STANDBY;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_STANDBY;
         gap_open   <= 1'b0;
         zero_seen  <= 1'b0;
         liw_stop   <= 1'b0;
         entry_fail <= 1'b0;
         bit_valid  <= 1'b0;
         bit_value  <= 1'b0;
      end else begin
         state <= state_nx;

         if (release_req)    gap_open <= 1'b0;
         else if (qual_rise) gap_open <= 1'b1;
         else if (gap_fall)  gap_open <= 1'b0;

         if (release_req || bit_end)                zero_seen <= 1'b0;
         else if (qual_rise && state != ST_STANDBY) zero_seen <= 1'b1;

         liw_stop   <= ~release_req & qual_rise & (state == ST_STANDBY);
         entry_fail <= ~release_req & bit_end & (state == ST_SECOND) & ~zero_seen;
         bit_valid  <= ~release_req & bit_end & (state == ST_RECEIVE);
         if (~release_req & bit_end & (state == ST_RECEIVE))
            bit_value <= ~zero_seen;
      end
   end
endmodule

// File: rtl/gap_bit_decoder.sv
module gap_bit_decoder
   import gbd_pkg::*;
#(
   parameter int BIT_LEN     = 32,
   parameter int RESYNC_CNT  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic car_tick,
   input  logic gap_det,
   input  logic liw_mod,
   input  logic rx_release,
   output logic mod_en,
   output logic liw_stop,
   output logic rm_entered,
   output logic entry_fail,
   output logic bit_valid,
   output logic bit_value
);
   localparam int CW   = $clog2(BIT_LEN);
   localparam int HALF = BIT_LEN / 2;

   generate
      if (BIT_LEN < 8 || (BIT_LEN % 2) != 0) begin : g_bad_len
         $error("gap_bit_decoder: BIT_LEN must be even and at least 8");
      end
      if (RESYNC_CNT < HALF || RESYNC_CNT >= BIT_LEN) begin : g_bad_reload
         $error("gap_bit_decoder: RESYNC_CNT must lie in the second half-slot");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("gap_bit_decoder: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic          gap_lvl;
   logic          gap_rise;
   logic          gap_fall;
   logic [CW-1:0] cnt;
   logic          first_half;
   logic          bit_end;
   logic          resync;
   rx_state_t     state;

   gbd_gap_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .gap_raw  (gap_det),
      .gap_lvl  (gap_lvl),
      .gap_rise (gap_rise),
      .gap_fall (gap_fall)
   );

   gbd_bit_timer #(.BIT_LEN(BIT_LEN), .RESYNC_CNT(RESYNC_CNT)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (car_tick),
      .hold       (gap_lvl),
      .resync     (resync),
      .cnt        (cnt),
      .first_half (first_half),
      .bit_end    (bit_end)
   );

   gbd_entry_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .gap_rise    (gap_rise),
      .gap_fall    (gap_fall),
      .liw_mod     (liw_mod),
      .first_half  (first_half),
      .bit_end     (bit_end),
      .release_req (rx_release),
      .state       (state),
      .resync      (resync),
      .liw_stop    (liw_stop),
      .entry_fail  (entry_fail),
      .bit_valid   (bit_valid),
      .bit_value   (bit_value)
   );

   assign rm_entered = (state == ST_RECEIVE);
   assign mod_en     = (state != ST_STANDBY) & first_half;
endmodule

// File: rtl/gbd_checker.sv
module gbd_checker #(
   parameter int BIT_LEN    = 32,
   parameter int RESYNC_CNT = 16,
   localparam int CW        = $clog2(BIT_LEN)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          car_tick,
   input logic          hold,
   input logic          resync,
   input logic [CW-1:0] cnt,
   input logic          mod_en,
   input logic          liw_stop,
   input logic          rm_entered,
   input logic          entry_fail,
   input logic          bit_valid
);
   localparam logic [CW-1:0] LAST = CW'(BIT_LEN - 1);
   localparam logic [CW-1:0] ONE  = CW'(1);

   // R2: every accepted strobe moves the count by one, wrapping at the end
   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (car_tick && !hold && !resync) |=>
         (cnt == (($past(cnt) == LAST) ? '0 : $past(cnt) + ONE)));

   // R3: no strobe, or a strobe inside a gap, leaves the count alone
   assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((!car_tick || hold) && !resync) |=> $stable(cnt));

   // R4: gap end reloads the count
   assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      resync |=> (cnt == CW'(RESYNC_CNT)));

   // R6: bit strobe lasts one cycle and only in receive mode
   assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |=> !bit_valid);
   assert_valid_in_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |-> rm_entered);

   // R8: listen-window stop only from standby, single cycle
   assert_stop_standby_R8: assert property (@(posedge clk) disable iff (!rst_n)
      liw_stop |-> (!rm_entered && !bit_valid));
   assert_stop_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      liw_stop |=> !liw_stop);

   // R9: receive mode is entered on a slot boundary, taken on a strobe
   assert_entry_on_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rm_entered) |-> $past(car_tick));

   // R10: failed entry leaves the block in standby with the modulator off
   assert_fail_standby_R10: assert property (@(posedge clk) disable iff (!rst_n)
      entry_fail |-> (!rm_entered && !mod_en && !bit_valid));
endmodule

bind gap_bit_decoder gbd_checker #(.BIT_LEN(BIT_LEN), .RESYNC_CNT(RESYNC_CNT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .car_tick   (car_tick),
   .hold       (gap_lvl),
   .resync     (resync),
   .cnt        (cnt),
   .mod_en     (mod_en),
   .liw_stop   (liw_stop),
   .rm_entered (rm_entered),
   .entry_fail (entry_fail),
   .bit_valid  (bit_valid)
);

// File: tb/sim_gap_bit_decoder.sv
module sim_gap_bit_decoder;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic car_tick = 1'b0;
   logic gap_det = 1'b0;
   logic liw_mod = 1'b0;
   logic rx_release = 1'b0;
   logic mod_en, liw_stop, rm_entered, entry_fail, bit_valid, bit_value;

   always #10 clk = ~clk;

   gap_bit_decoder u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .car_tick   (car_tick),
      .gap_det    (gap_det),
      .liw_mod    (liw_mod),
      .rx_release (rx_release),
      .mod_en     (mod_en),
      .liw_stop   (liw_stop),
      .rm_entered (rm_entered),
      .entry_fail (entry_fail),
      .bit_valid  (bit_valid),
      .bit_value  (bit_value)
   );

   // kind: 0 early-gap zero, 1 carrier-only one, 2 late gap (reads 1), 3 zero with strobes inside the gap
   localparam int NV = 10;
   localparam int VKIND [NV] = '{1, 0, 0, 2, 1, 3, 0, 1, 2, 0};
   localparam int VPRE  [NV] = '{0, 4, 1, 0, 0, 5, 6, 0, 0, 2};

   int nchk = 0;
   int nbad = 0;
   int ncap = 0;
   int nstop = 0;
   int nfe = 0;
   logic cap [64];
   bit done = 1'b0;

   always @(negedge clk) begin
      if (bit_valid) begin
         if (ncap < 64) cap[ncap] = bit_value;
         ncap = ncap + 1;
      end
      if (liw_stop)   nstop = nstop + 1;
      if (entry_fail) nfe = nfe + 1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nchk = nchk + 1;
      if (!ok) begin
         nbad = nbad + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) car_tick = 1'b1;
         @(negedge clk) car_tick = 1'b0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic gap(input int inner);
      @(negedge clk) gap_det = 1'b1;
      repeat (4) @(negedge clk);
      ticks(inner);
      repeat (4) @(negedge clk);
      gap_det = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_bit(input int kind, input int pre);
      case (kind)
         0: begin ticks(pre); gap(0); ticks(16); end
         3: begin ticks(pre); gap(3); ticks(16); end
         2: begin ticks(20); gap(0); ticks(12); end
         default: ticks(32);
      endcase
   endtask

   task automatic start_entry();
      liw_mod = 1'b1;
      ticks(2);
      gap(0);
      liw_mod = 1'b0;
      ticks(16);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", nchk - nbad, nchk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk = nchk + 1;
         nbad = nbad + 1;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         report();
      end
   end

   initial begin
      int base;
      int c0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check({mod_en, liw_stop, rm_entered, entry_fail, bit_valid, bit_value} == 6'b0,
            "R1", {mod_en, liw_stop, rm_entered, entry_fail, bit_valid, bit_value}, 0);
      rst_n = 1'b1;
      ticks(5);

      // R8: gap outside the listen window is ignored
      gap(0);
      ticks(8);
      check(nstop == 0, "R8", nstop, 0);
      check(!rm_entered && !mod_en, "R8", {rm_entered, mod_en}, 0);

      // R8/R5/R9 entry
      start_entry();
      check(nstop == 1, "R8", nstop, 1);
      check(mod_en == 1'b1, "R5", mod_en, 1);
      send_bit(0, 4);
      check(rm_entered == 1'b1, "R9", rm_entered, 1);
      check(ncap == 0, "R9", ncap, 0);

      // R2/R5 slot timing in receive mode
      c0 = ncap;
      ticks(8);
      check(mod_en == 1'b1, "R5", mod_en, 1);
      ticks(12);
      check(mod_en == 1'b0, "R5", mod_en, 0);
      ticks(11);
      check(ncap == c0, "R2", ncap, c0);
      ticks(1);
      check(ncap == c0 + 1, "R2", ncap, c0 + 1);
      check(cap[c0] == 1'b1, "R6", cap[c0], 1);

      // R6/R4/R7/R3 vector table
      base = ncap;
      for (int v = 0; v < NV; v++) send_bit(VKIND[v], VPRE[v]);
      check(ncap == base + NV, "R6", ncap, base + NV);
      for (int v = 0; v < NV; v++) begin
         int exp;
         exp = (VKIND[v] == 0 || VKIND[v] == 3) ? 0 : 1;
         if (VKIND[v] == 2)      check(cap[base + v] == exp[0], "R7", cap[base + v], exp);
         else if (VKIND[v] == 3) check(cap[base + v] == exp[0], "R3", cap[base + v], exp);
         else if (VKIND[v] == 0) check(cap[base + v] == exp[0], "R4", cap[base + v], exp);
         else                    check(cap[base + v] == exp[0], "R6", cap[base + v], exp);
      end

      // R11 release
      @(negedge clk) rx_release = 1'b1;
      @(negedge clk) rx_release = 1'b0;
      c0 = ncap;
      check(!rm_entered && !mod_en, "R11", {rm_entered, mod_en}, 0);
      ticks(40);
      check(ncap == c0, "R11", ncap, c0);

      // R10 entry failure
      start_entry();
      check(nstop == 2, "R8", nstop, 2);
      send_bit(1, 0);
      check(nfe == 1, "R10", nfe, 1);
      check(!rm_entered && !mod_en, "R10", {rm_entered, mod_en}, 0);
      ticks(8);
      check(ncap == c0, "R10", ncap, c0);

      // R1 reset while in receive mode
      start_entry();
      send_bit(0, 3);
      check(rm_entered == 1'b1, "R9", rm_entered, 1);
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk);
      check({mod_en, rm_entered, bit_valid} == 3'b0, "R1", {mod_en, rm_entered, bit_valid}, 0);
      rst_n = 1'b1;

      done = 1'b1;
      report();
   end
endmodule